// File: doc/BRIEF.md
# Windowed Watchdog with Reset Pulse Generator

This block supervises a processor through a single service line. Each falling edge on `wdiIn` is a service strobe. The watchdog period is split into two parts. First comes a closed window, where a strobe is too early. Then comes an open window, where a strobe is accepted. A strobe in the closed window is an early fault. A period that ends with no strobe at all is a late fault. Either fault drives the active-low `wdRstN` output low for a programmable number of clock cycles. An accepted strobe restarts the period from zero.

A digital supply-good input, `monOk`, also controls reset. Reset is forced while `monOk` is low. Once `monOk` returns high, reset is held for the full reset time. The same hold sequence runs after the block's own reset, which gives a power-on reset.

Two single-cycle event pulses are provided for a downstream failure tracker. `evtFault` marks a watchdog fault. `evtGood` marks an accepted strobe. All durations are parameters counted in clock cycles. The service line is taken as already synchronous to `clk`.

Top module: `winWatchdog`

## Requirements
- R1: The closed window lasts `CLOSED = PERIOD_CYC*(100-OPEN_PCT)/100` cycles and the open window covers the rest of `PERIOD_CYC`. `OPEN_PCT` selects 50, 75 or 100.
- R2: Count k from the clock edge where `wdRstN` rose, or where the last strobe was accepted. If a falling edge is sampled at the (k+1)-th later clock edge with k < CLOSED, that edge is an early fault. `wdRstN` goes low and `evtFault` pulses at that same edge.
- R3: A falling edge sampled with CLOSED <= k <= PERIOD_CYC-1 is accepted. `evtGood` pulses, `wdRstN` stays high, and k restarts from zero.
- R4: If no falling edge arrives, a late fault happens at the PERIOD_CYC-th clock edge after k restarted. `wdRstN` goes low and `evtFault` pulses.
- R5: After a fault, `wdRstN` stays low and rises at the RST_CYC-th following clock edge at which `monOk` is high.
- R6: While `wdRstN` is low, falling edges on `wdiIn` cause no `evtGood`, no `evtFault`, and no change to the release time.
- R7: `monOk` low at a clock edge drives `wdRstN` low at that edge, without an `evtFault` pulse. It restarts the hold count. Release follows at the RST_CYC-th clock edge with `monOk` high.
- R8: While `rstN` is low, `wdRstN`, `evtFault` and `evtGood` are all low. After `rstN` rises, the release follows R5.
- R9: `evtFault` and `evtGood` each last exactly one cycle and are never high together.
- R10: With `OPEN_PCT` = 100 there is no closed window. Every falling edge with k <= PERIOD_CYC-1 is accepted.
- R11: A falling edge at exactly k = CLOSED counts as open-window (accepted).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low block reset |
| wdiIn | input | 1 | Service line; falling edges are strobes |
| monOk | input | 1 | Supply-good level; low forces reset |
| wdRstN | output | 1 | Active-low reset to the supervised processor |
| evtFault | output | 1 | One-cycle pulse on an early or late fault |
| evtGood | output | 1 | One-cycle pulse on an accepted strobe |

## Verification
A window counter that is off by one shows up first at the window boundary. A strobe with k one below or at CLOSED then gives the wrong event in the very cycle it is sampled. The same error also moves the late fault by one edge. A hold counter that runs wrong, or that keeps counting while `monOk` is low, shows up as `wdRstN` rising one or more edges early or late. A watchdog counter that was not cleared during reset shifts every window in the next trial. For this reason each strobe delay in the sweep is started from a freshly released state.

// File: rtl/wdPkg.sv
package wdPkg;

  typedef enum logic {
    ST_HOLD = 1'b0,
    ST_RUN  = 1'b1
  } wdState_t;

  // control -> datapath
  typedef struct packed {
    logic clrWd;
    logic incWd;
    logic clrRst;
    logic incRst;
  } wdStrobes_t;

  // datapath -> control
  typedef struct packed {
    logic fallSeen;
    logic inClosed;
    logic wdLast;
    logic rstLast;
  } wdFlags_t;

endpackage

// File: rtl/wdDatapath.sv
module wdDatapath
  import wdPkg::*;
#(
  parameter int PERIOD_CYC = 40,
  parameter int CLOSED_CYC = 20,
  parameter int RST_CYC    = 12
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wdiIn,
  input  wdStrobes_t strb,
  output wdFlags_t   flags
);

  localparam int WD_W = $clog2(PERIOD_CYC + 1);
  localparam int RS_W = $clog2(RST_CYC + 1);

  logic            wdiPrev;
  logic [WD_W-1:0] wdCnt;
  logic [RS_W-1:0] rstCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdiPrev <= 1'b1;
      wdCnt   <= '0;
      rstCnt  <= '0;
    end else begin
      wdiPrev <= wdiIn;
      if (strb.clrWd)       wdCnt <= '0;
      else if (strb.incWd)  wdCnt <= wdCnt + 1'b1;
      if (strb.clrRst)      rstCnt <= '0;
      else if (strb.incRst) rstCnt <= rstCnt + 1'b1;
    end
  end

  assign flags.fallSeen = wdiPrev & ~wdiIn;
  assign flags.wdLast   = (wdCnt == WD_W'(PERIOD_CYC - 1));
  assign flags.rstLast  = (rstCnt == RS_W'(RST_CYC - 1));

  generate
    if (CLOSED_CYC == 0) begin : g_plainTimeout
      assign flags.inClosed = 1'b0;
    end else begin : g_window
      assign flags.inClosed = (wdCnt < WD_W'(CLOSED_CYC));
    end
  endgenerate

  // R4
  wd_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    wdCnt <= WD_W'(PERIOD_CYC - 1));

  // R5
  rst_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstCnt <= RS_W'(RST_CYC - 1));

endmodule

// File: rtl/wdControl.sv
module wdControl
  import wdPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       monOk,
  input  wdFlags_t   flags,
  output wdStrobes_t strb,
  output logic       wdRstN,
  output logic       evtFault,
  output logic       evtGood
);

  wdState_t state, nextState;
  logic     faultNxt, goodNxt;

  always_comb begin
    nextState = state;
    strb      = '0;
    faultNxt  = 1'b0;
    goodNxt   = 1'b0;
    unique case (state)
      ST_HOLD: begin
        strb.clrWd = 1'b1;
        if (!monOk) begin
          strb.clrRst = 1'b1;
        end else if (flags.rstLast) begin
          strb.clrRst = 1'b1;
          nextState   = ST_RUN;
        end else begin
          strb.incRst = 1'b1;
        end
      end
      ST_RUN: begin
        strb.clrRst = 1'b1;
        if (!monOk) begin
          strb.clrWd = 1'b1;
          nextState  = ST_HOLD;
        end else if (flags.fallSeen) begin
          strb.clrWd = 1'b1;
          if (flags.inClosed) begin
            faultNxt  = 1'b1;
            nextState = ST_HOLD;
          end else begin
            goodNxt = 1'b1;
          end
        end else if (flags.wdLast) begin
          strb.clrWd = 1'b1;
          faultNxt   = 1'b1;
          nextState  = ST_HOLD;
        end else begin
          strb.incWd = 1'b1;
        end
      end
      default: nextState = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_HOLD;
      evtFault <= 1'b0;
      evtGood  <= 1'b0;
    end else begin
      state    <= nextState;
      evtFault <= faultNxt;
      evtGood  <= goodNxt;
    end
  end

  assign wdRstN = (state == ST_RUN);

  // R9
  event_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(evtFault && evtGood));

  // R7
  mon_force_chk: assert property (@(posedge clk) disable iff (!rstN)
    !monOk |=> !wdRstN);

  // R2
  fault_rst_chk: assert property (@(posedge clk) disable iff (!rstN)
    evtFault |-> !wdRstN);

  // R6
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wdRstN |-> !evtGood);

  // R5
  release_time_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wdRstN) |-> $past(flags.rstLast && monOk));

endmodule

// File: rtl/winWatchdog.sv
module winWatchdog
  import wdPkg::*;
#(
  parameter int PERIOD_CYC = 40,
  parameter int OPEN_PCT   = 50,
  parameter int RST_CYC    = 12
) (
  input  logic clk,
  input  logic rstN,
  input  logic wdiIn,
  input  logic monOk,
  output logic wdRstN,
  output logic evtFault,
  output logic evtGood
);

  localparam int CLOSED_CYC = (PERIOD_CYC * (100 - OPEN_PCT)) / 100;

  wdStrobes_t strb;
  wdFlags_t   flags;

  wdDatapath #(
    .PERIOD_CYC(PERIOD_CYC),
    .CLOSED_CYC(CLOSED_CYC),
    .RST_CYC   (RST_CYC)
  ) u_dp (
    .clk  (clk),
    .rstN (rstN),
    .wdiIn(wdiIn),
    .strb (strb),
    .flags(flags)
  );

  wdControl u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .monOk   (monOk),
    .flags   (flags),
    .strb    (strb),
    .wdRstN  (wdRstN),
    .evtFault(evtFault),
    .evtGood (evtGood)
  );

  // R1
  initial begin
    pct_legal_chk: assert (OPEN_PCT == 50 || OPEN_PCT == 75 || OPEN_PCT == 100);
  end

endmodule

// File: tb/winWatchdog_bench.sv
module winWatchdog_bench;

  localparam int CLK_PERIOD = 10;
  localparam int PERIOD     = 40;
  localparam int PCT        = 50;
  localparam int RSTC       = 12;
  localparam int CLOSED     = PERIOD * (100 - PCT) / 100;

  logic clk = 1'b0;
  logic rstN, wdiIn, monOk;
  logic rst1, flt1, gd1, rst2, flt2, gd2;
  int   checks = 0;
  int   failures = 0;
  bit   done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  winWatchdog #(.PERIOD_CYC(PERIOD), .OPEN_PCT(PCT), .RST_CYC(RSTC)) u_winWatchdog (
    .clk(clk), .rstN(rstN), .wdiIn(wdiIn), .monOk(monOk),
    .wdRstN(rst1), .evtFault(flt1), .evtGood(gd1));

  winWatchdog #(.PERIOD_CYC(PERIOD), .OPEN_PCT(100), .RST_CYC(RSTC)) u_plain (
    .clk(clk), .rstN(rstN), .wdiIn(wdiIn), .monOk(monOk),
    .wdRstN(rst2), .evtFault(flt2), .evtGood(gd2));

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // drop monOk one cycle, then wait for release on both instances
  task automatic realign();
    monOk = 1'b0;
    wdiIn = 1'b1;
    tick();
    chk("R7", "rst1 forced", rst1, 1'b0);
    chk("R7", "no fault pulse", flt1, 1'b0);
    monOk = 1'b1;
    for (int i = 1; i <= RSTC; i++) begin
      tick();
      if (i == RSTC - 1) begin
        chk("R7", "rst1 still low", rst1, 1'b0);
        chk("R7", "rst2 still low", rst2, 1'b0);
      end
      if (i == RSTC) begin
        chk("R7", "rst1 released", rst1, 1'b1);
        chk("R7", "rst2 released", rst2, 1'b1);
      end
    end
  endtask

  initial begin
    rstN = 1'b0; wdiIn = 1'b1; monOk = 1'b1;
    repeat (3) tick();
    chk("R8", "rst in reset", rst1, 1'b0);
    chk("R8", "fault in reset", flt1, 1'b0);
    chk("R8", "good in reset", gd1, 1'b0);
    rstN = 1'b1;
    for (int i = 1; i <= RSTC; i++) begin
      tick();
      if (i == RSTC - 1) chk("R8", "power-on hold", rst1, 1'b0);
      if (i == RSTC)     chk("R8", "power-on release", rst1, 1'b1);
    end

    // sweep strobe delay k across the whole period and past it
    for (int k = 0; k <= PERIOD + 1; k++) begin
      bit good1, good2;
      realign();
      for (int s = 1; s <= k; s++) begin
        tick();
        if (s == PERIOD - 1) chk("R4", "no early late fault", rst1, 1'b1);
        if (s == PERIOD) begin
          chk("R4", "late fault pulse", flt1, 1'b1);
          chk("R4", "late fault reset", rst1, 1'b0);
          chk("R10", "late fault plain", flt2, 1'b1);
        end
        if (s == PERIOD + 1) chk("R9", "fault pulse one cycle", flt1, 1'b0);
      end
      wdiIn = 1'b0;
      tick();
      good1 = (k >= CLOSED) && (k < PERIOD);
      good2 = (k < PERIOD);
      if (k < PERIOD) begin
        if (k == CLOSED)         chk("R11", "boundary edge good", gd1, 1'b1);
        else if (k == CLOSED - 1) chk("R1", "last closed cycle", flt1, 1'b1);
        else if (good1)          chk("R3", "open edge good", gd1, 1'b1);
        else                     chk("R2", "closed edge fault", flt1, 1'b1);
        chk(good1 ? "R3" : "R2", "event exclusivity", good1 ? flt1 : gd1, 1'b0);
        chk(good1 ? "R3" : "R2", "reset level", rst1, good1);
        chk("R10", "plain accepts edge", gd2, good2);
      end else begin
        chk("R6", "edge ignored in hold", gd1, 1'b0);
        chk("R6", "edge no fault in hold", flt1, 1'b0);
      end
      wdiIn = 1'b1;
      tick();
      chk("R9", "good pulse one cycle", gd1, 1'b0);

      if (k == CLOSED) begin
        for (int s = 2; s <= CLOSED; s++) tick();
        wdiIn = 1'b0;
        tick();
        chk("R3", "restart then boundary edge", gd1, 1'b1);
        chk("R3", "restart keeps reset high", rst1, 1'b1);
        wdiIn = 1'b1;
      end

      if (k == 0) begin
        // fault sampled at edge F; already one tick after F here
        for (int i = 2; i <= RSTC; i++) begin
          wdiIn = i[0];
          tick();
          chk("R6", "no good in hold", gd1, 1'b0);
          if (i == RSTC - 1) chk("R5", "hold after fault", rst1, 1'b0);
          if (i == RSTC)     chk("R5", "release after fault", rst1, 1'b1);
        end
        wdiIn = 1'b1;
      end
    end

    // monitor dip during hold restarts the count
    realign();
    monOk = 1'b0; tick();
    monOk = 1'b1; repeat (3) tick();
    monOk = 1'b0; tick();
    chk("R7", "held by monitor", rst1, 1'b0);
    monOk = 1'b1;
    for (int i = 1; i <= RSTC; i++) begin
      tick();
      chk("R7", "no fault from monitor", flt1, 1'b0);
      if (i == RSTC - 1) chk("R7", "hold restarted", rst1, 1'b0);
      if (i == RSTC)     chk("R7", "release after dip", rst1, 1'b1);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule